// File: doc/BRIEF.md
# Boost Converter Start-Up and Fault Retry Sequencer

This block is the digital sequencer that brings a boost converter up from off to regulation and walks it back through a timed retry whenever something goes wrong. After enable, it runs a linear precharge in two current levels, each with its own time budget. It then switches at a fixed duty with a reduced current limit until the output clears a minimum level. After that it hands over to the closed loop, which must reach regulation within a short window.

While switching, the sequencer watches a per-cycle current-limit flag. A run of limited cycles trips it, and so does a limit held for too long. Every failure leads to the same retry: the switching outputs go quiet for a long pause, and then the whole start-up repeats. Thermal shutdown overrides everything until the die cools to the warning level. Power-good is high only after a completed start-up, and only while the output is in its window and no thermal warning is active. The analog parts sit outside the block: the comparators supply the flags, and the stage selects drive the current sources and the modulator. All intervals are counted in microsecond ticks derived from the system clock.

Top module: `boost_startup_seq`

## Requirements
- R1: While reset is low or `en_i` is low, all six outputs are low.
- R2: On enable, `lin_lo_o` alone is high for LIN1_US microsecond ticks (LIN1_US*CLK_PER_US clock cycles), measured from the edge that leaves the off state.
- R3: If `out_near_in_i` stays low through the first stage, `lin_hi_o` alone is high for LIN2_US ticks. If it is still low at the end of that stage, the block enters the retry state with `fault_o` high.
- R4: `out_near_in_i` high in either linear stage moves the block to fixed-duty boost (`boost_fixed_o` high) on the next edge. If this happens in the same cycle that the first stage expires, the fixed-duty step still wins.
- R5: In fixed-duty boost, `out_above_min_i` high moves the block to closed loop: `loop_en_o` goes high and `boost_fixed_o` goes low.
- R6: In closed loop, `in_reg_i` high within REG_US ticks moves the block to the running state. It also does so when it arrives on the expiry cycle. Otherwise the block enters retry.
- R7: In any switching state (fixed duty, closed loop, running), the sixteenth (OC_CYCLES) consecutive `sw_cycle_i` strobe with `ilim_hit_i` high enters retry. A strobe with `ilim_hit_i` low restarts the count.
- R8: `ilim_hit_i` held high without a break for CLAMP_US ticks in a switching state enters retry.
- R9: In retry, `fault_o` alone is high for HICCUP_US ticks, and then the block restarts at the first linear stage.
- R10: `pg_o` is high only in the running state, and only while `in_reg_i` is high and `therm_warn_i` is low. It follows those two inputs without delay.
- R11: `therm_sd_i` high with enable forces all outputs low on the next edge. The block stays there until both thermal flags are low, and then restarts at the first linear stage.
- R12: `en_i` low returns the block to the off state on the next edge and clears every counter. A later enable starts a fresh precharge.
- R13: If an overcurrent trip and `in_reg_i` arrive in the same closed-loop cycle, the block enters retry and not the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| out_near_in_i | input | 1 | Output within 300 mV of input |
| out_above_min_i | input | 1 | Output above 2.3 V |
| in_reg_i | input | 1 | Output inside its regulation window (at least 96 % of target) |
| sw_cycle_i | input | 1 | One-cycle strobe per switching period |
| ilim_hit_i | input | 1 | Current limit reached in the present switching period |
| therm_warn_i | input | 1 | Die at or above the warning temperature |
| therm_sd_i | input | 1 | Die at or above the shutdown temperature |
| lin_lo_o | output | 1 | Linear precharge, lower current |
| lin_hi_o | output | 1 | Linear precharge, higher current |
| boost_fixed_o | output | 1 | Fixed 75 % duty boost with reduced current limit |
| loop_en_o | output | 1 | Closed-loop regulation enabled |
| fault_o | output | 1 | Retry pause after a fault |
| pg_o | output | 1 | Power good |

## Verification
Two functions can land in the same cycle: the arrival of regulation in closed loop and an overcurrent trip. The bench builds this case by sending fifteen limited strobes during fixed-duty boost, which has no timeout, and then moving to closed loop. It then raises the sixteenth limited strobe and `in_reg_i` together on one cycle. The next edge must show `fault_o` high with `loop_en_o` and `pg_o` low. Two other races get the same treatment: the precharge threshold against the first-stage expiry, and regulation against the closed-loop expiry. In both, progress is expected to win.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_LIN1   = 3'd1,
    ST_LIN2   = 3'd2,
    ST_OPEN   = 3'd3,
    ST_CLOSED = 3'd4,
    ST_RUN    = 3'd5,
    ST_HICCUP = 3'd6,
    ST_TSD    = 3'd7
  } seq_state_e;

  function automatic logic is_switching(input seq_state_e s);
    return (s == ST_OPEN) || (s == ST_CLOSED) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/us_interval_timer.sv
module us_interval_timer #(
  parameter int CLK_PER_US = 100,
  parameter int CW         = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic [CW-1:0] limit_i,
  output logic          tick_o,
  output logic          expire_o
);

  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [PW-1:0] presc_q, presc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o   = (presc_q == PW'(CLK_PER_US - 1));
  assign expire_o = tick_o && (cnt_q == (limit_i - CW'(1)));
  assign cnt_en   = tick_o && (cnt_q != {CW{1'b1}});

  always_comb begin
    if (restart_i)   presc_d = '0;
    else if (tick_o) presc_d = '0;
    else             presc_d = presc_q + PW'(1);
  end

  always_comb begin
    if (restart_i)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CW'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
    end
  end

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart_i) |=> !tick_o);
    end
  endgenerate

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!expire_o || limit_i == CW'(1)));

endmodule

// File: rtl/oc_monitor.sv
module oc_monitor #(
  parameter int OC_CYCLES = 16,
  parameter int CLAMP_US  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  input  logic cyc_i,
  input  logic ilim_i,
  output logic trip_o
);

  localparam int NW = $clog2(OC_CYCLES + 1);
  localparam int HW = $clog2(CLAMP_US + 1);

  logic [NW-1:0] run_q, run_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          run_trip, hold_trip;

  assign run_trip  = !clr_i && cyc_i && ilim_i && (run_q == NW'(OC_CYCLES - 1));
  assign hold_trip = !clr_i && tick_i && ilim_i && (hold_q == HW'(CLAMP_US - 1));
  assign trip_o    = run_trip || hold_trip;

  always_comb begin
    run_d = run_q;
    if (clr_i)                                     run_d = '0;
    else if (cyc_i && !ilim_i)                     run_d = '0;
    else if (cyc_i && run_q != NW'(OC_CYCLES - 1)) run_d = run_q + NW'(1);
  end

  always_comb begin
    hold_d = hold_q;
    if (clr_i || !ilim_i)                          hold_d = '0;
    else if (tick_i && hold_q != HW'(CLAMP_US - 1)) hold_d = hold_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
    end
  end

  assert_miss_clears_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cyc_i && !ilim_i) |=> (run_q == '0));

  assert_trip_needs_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> ilim_i);

endmodule

// File: rtl/boost_startup_seq.sv
module boost_startup_seq
  import boost_seq_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int LIN1_US    = 512,
  parameter int LIN2_US    = 1024,
  parameter int REG_US     = 64,
  parameter int HICCUP_US  = 20000,
  parameter int CLAMP_US   = 2000,
  parameter int OC_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic out_near_in_i,
  input  logic out_above_min_i,
  input  logic in_reg_i,
  input  logic sw_cycle_i,
  input  logic ilim_hit_i,
  input  logic therm_warn_i,
  input  logic therm_sd_i,
  output logic lin_lo_o,
  output logic lin_hi_o,
  output logic boost_fixed_o,
  output logic loop_en_o,
  output logic fault_o,
  output logic pg_o
);

  localparam int MAX_A  = (LIN1_US > LIN2_US) ? LIN1_US : LIN2_US;
  localparam int MAX_B  = (REG_US > HICCUP_US) ? REG_US : HICCUP_US;
  localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_US + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] limit;
  logic          restart, tick, expire, oc_trip, oc_clr;

  always_comb begin
    case (state_q)
      ST_LIN1:   limit = CW'(LIN1_US);
      ST_LIN2:   limit = CW'(LIN2_US);
      ST_HICCUP: limit = CW'(HICCUP_US);
      default:   limit = CW'(REG_US);
    endcase
  end

  assign restart = (state_d != state_q);
  assign oc_clr  = !en_i || !is_switching(state_q);

  us_interval_timer #(
    .CLK_PER_US (CLK_PER_US),
    .CW         (CW)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .limit_i   (limit),
    .tick_o    (tick),
    .expire_o  (expire)
  );

  oc_monitor #(
    .OC_CYCLES (OC_CYCLES),
    .CLAMP_US  (CLAMP_US)
  ) u_oc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (oc_clr),
    .tick_i (tick),
    .cyc_i  (sw_cycle_i),
    .ilim_i (ilim_hit_i),
    .trip_o (oc_trip)
  );

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_OFF;
    end else if (therm_sd_i) begin
      state_d = ST_TSD;
    end else begin
      case (state_q)
        ST_OFF:  state_d = ST_LIN1;
        ST_LIN1: begin
          if (out_near_in_i) state_d = ST_OPEN;
          else if (expire)   state_d = ST_LIN2;
        end
        ST_LIN2: begin
          if (out_near_in_i) state_d = ST_OPEN;
          else if (expire)   state_d = ST_HICCUP;
        end
        ST_OPEN: begin
          if (oc_trip)              state_d = ST_HICCUP;
          else if (out_above_min_i) state_d = ST_CLOSED;
        end
        ST_CLOSED: begin
          if (oc_trip)       state_d = ST_HICCUP;
          else if (in_reg_i) state_d = ST_RUN;
          else if (expire)   state_d = ST_HICCUP;
        end
        ST_RUN: begin
          if (oc_trip) state_d = ST_HICCUP;
        end
        ST_HICCUP: begin
          if (expire) state_d = ST_LIN1;
        end
        ST_TSD: begin
          if (!therm_warn_i) state_d = ST_LIN1;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign lin_lo_o      = (state_q == ST_LIN1);
  assign lin_hi_o      = (state_q == ST_LIN2);
  assign boost_fixed_o = (state_q == ST_OPEN);
  assign loop_en_o     = (state_q == ST_CLOSED) || (state_q == ST_RUN);
  assign fault_o       = (state_q == ST_HICCUP);
  assign pg_o          = (state_q == ST_RUN) && in_reg_i && !therm_warn_i;

  assert_off_when_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_q == ST_OFF));

  assert_stage_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lin_lo_o, lin_hi_o, boost_fixed_o, loop_en_o, fault_o}));

  assert_pg_needs_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pg_o |-> (loop_en_o && in_reg_i && !therm_warn_i));

  assert_shutdown_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && therm_sd_i) |=> !(lin_lo_o || lin_hi_o || boost_fixed_o || loop_en_o || fault_o));

  assert_retry_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && expire && en_i && !therm_sd_i) |=> lin_lo_o);

  assert_trip_beats_reg_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLOSED && oc_trip && en_i && !therm_sd_i) |=> (fault_o && !pg_o));

endmodule

// File: tb/tb_boost_startup_seq.sv
module tb_boost_startup_seq;

  logic clk, rst_n;
  logic en, near, above, inreg, cyc, ilim, warn, sd;
  logic lin_lo, lin_hi, fixd, loop_en, fault, pg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  boost_startup_seq #(
    .CLK_PER_US (2),
    .LIN1_US    (4),
    .LIN2_US    (6),
    .REG_US     (3),
    .HICCUP_US  (5),
    .CLAMP_US   (4),
    .OC_CYCLES  (16)
  ) dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_i            (en),
    .out_near_in_i   (near),
    .out_above_min_i (above),
    .in_reg_i        (inreg),
    .sw_cycle_i      (cyc),
    .ilim_hit_i      (ilim),
    .therm_warn_i    (warn),
    .therm_sd_i      (sd),
    .lin_lo_o        (lin_lo),
    .lin_hi_o        (lin_hi),
    .boost_fixed_o   (fixd),
    .loop_en_o       (loop_en),
    .fault_o         (fault),
    .pg_o            (pg)
  );

  // Vector: [25:22] requirement, [21:14] {en,near,above,inreg,ilim,cyc,warn,sd},
  // [13:6] clock edges to wait, [5:0] expected {lin_lo,lin_hi,fixed,loop,fault,pg}
  localparam int NV = 24;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1,  8'b0000_0000, 8'd3, 6'b000000},  // R1 off while disabled
    {4'd2,  8'b1000_0000, 8'd1, 6'b100000},  // R2 first stage entered
    {4'd2,  8'b1000_0000, 8'd7, 6'b100000},  // R2 still first stage at 7 cycles
    {4'd3,  8'b1000_0000, 8'd1, 6'b010000},  // R3 second stage at 8 cycles
    {4'd4,  8'b1100_0000, 8'd1, 6'b001000},  // R4 threshold -> fixed duty
    {4'd5,  8'b1110_0000, 8'd1, 6'b000100},  // R5 above minimum -> closed loop
    {4'd10, 8'b1111_0000, 8'd1, 6'b000101},  // R10 running, power good
    {4'd10, 8'b1111_0010, 8'd1, 6'b000100},  // R10 warning drops pg
    {4'd10, 8'b1110_0000, 8'd1, 6'b000100},  // R10 out of window drops pg
    {4'd10, 8'b1111_0000, 8'd1, 6'b000101},  // R10 pg back
    {4'd12, 8'b0111_0000, 8'd1, 6'b000000},  // R12 disable -> off
    {4'd2,  8'b1100_0000, 8'd1, 6'b100000},  // R2 restart at first stage
    {4'd4,  8'b1100_0000, 8'd1, 6'b001000},  // R4 threshold seen in first stage
    {4'd5,  8'b1110_0000, 8'd1, 6'b000100},  // R5 closed loop
    {4'd6,  8'b1110_0000, 8'd5, 6'b000100},  // R6 still waiting at 5 cycles
    {4'd6,  8'b1110_0000, 8'd1, 6'b000010},  // R6 timeout -> retry
    {4'd9,  8'b1110_0000, 8'd9, 6'b000010},  // R9 retry held 9 cycles
    {4'd9,  8'b1110_0000, 8'd1, 6'b100000},  // R9 retry ends -> first stage
    {4'd6,  8'b1111_0000, 8'd2, 6'b000100},  // R6 back to closed loop
    {4'd6,  8'b1111_0000, 8'd1, 6'b000101},  // R6 regulation -> running
    {4'd11, 8'b1111_0011, 8'd1, 6'b000000},  // R11 shutdown
    {4'd11, 8'b1111_0010, 8'd3, 6'b000000},  // R11 held while warning
    {4'd11, 8'b1111_0000, 8'd1, 6'b100000},  // R11 resume at first stage
    {4'd12, 8'b0000_0000, 8'd1, 6'b000000}   // R12 off again
  };

  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {lin_lo, lin_hi, fixd, loop_en, fault, pg};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input int k, input logic hit);
    for (int s = 0; s < k; s++) begin
      cyc = 1'b1; ilim = hit;
      @(negedge clk);
      cyc = 1'b0; ilim = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    {en, near, above, inreg, ilim, cyc, warn, sd} = '0;
    wait_n(3);
    chk("R1 reset", 6'b000000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {en, near, above, inreg, ilim, cyc, warn, sd} = VEC[i][21:14];
      wait_n(int'(VEC[i][13:6]));
      chk($sformatf("R%0d vector %0d", VEC[i][25:22], i), VEC[i][5:0]);
    end

    // R3: second stage times out into retry
    en = 1'b1;
    wait_n(1);
    wait_n(8);
    chk("R3 second stage", 6'b010000);
    wait_n(11);
    chk("R3 second stage end", 6'b010000);
    wait_n(1);
    chk("R3 timeout fault", 6'b000010);
    en = 1'b0;
    wait_n(1);

    // R4: threshold on the first-stage expiry cycle wins
    en = 1'b1;
    wait_n(8);
    near = 1'b1;
    wait_n(1);
    chk("R4 threshold at expiry", 6'b001000);
    en = 1'b0; near = 1'b0;
    wait_n(1);

    // R6: regulation on the closed-loop expiry cycle wins
    en = 1'b1; near = 1'b1;
    wait_n(2);
    above = 1'b1;
    wait_n(1);
    wait_n(5);
    inreg = 1'b1;
    wait_n(1);
    chk("R6 regulation at expiry", 6'b000101);

    // R7: consecutive limited cycles, with a miss restarting the run
    strobes(15, 1'b1);
    chk("R7 fifteen hits", 6'b000101);
    strobes(1, 1'b0);
    strobes(15, 1'b1);
    chk("R7 run restarted by miss", 6'b000101);
    cyc = 1'b1; ilim = 1'b1;
    wait_n(1);
    cyc = 1'b0; ilim = 1'b0;
    chk("R7 sixteenth hit trips", 6'b000010);

    // R12: disable clears counters
    en = 1'b0;
    wait_n(1);
    chk("R12 disable", 6'b000000);
    en = 1'b1;
    wait_n(4);
    chk("R12 running again", 6'b000101);
    strobes(10, 1'b1);
    en = 1'b0;
    wait_n(1);
    en = 1'b1;
    wait_n(4);
    strobes(15, 1'b1);
    chk("R12 count cleared", 6'b000101);

    // R8: current limit held for too long
    ilim = 1'b1;
    wait_n(6);
    chk("R8 held below window", 6'b000101);
    wait_n(4);
    chk("R8 held limit trips", 6'b000010);
    ilim = 1'b0; en = 1'b0;
    wait_n(1);

    // R13: overcurrent trip and regulation in the same closed-loop cycle
    en = 1'b1; near = 1'b1; above = 1'b0; inreg = 1'b0;
    wait_n(2);
    chk("R13 fixed duty", 6'b001000);
    strobes(15, 1'b1);
    chk("R13 fifteen hits in fixed duty", 6'b001000);
    above = 1'b1;
    wait_n(1);
    chk("R13 closed loop", 6'b000100);
    cyc = 1'b1; ilim = 1'b1; inreg = 1'b1;
    wait_n(1);
    cyc = 1'b0; ilim = 1'b0;
    chk("R13 trip beats regulation", 6'b000010);

    // R11: shutdown from the first stage, resume only when cool
    en = 1'b0;
    wait_n(1);
    en = 1'b1; near = 1'b0; above = 1'b0; inreg = 1'b0;
    wait_n(1);
    sd = 1'b1; warn = 1'b1;
    wait_n(1);
    chk("R11 shutdown from precharge", 6'b000000);
    sd = 1'b0;
    wait_n(2);
    chk("R11 wait for warning clear", 6'b000000);
    warn = 1'b0;
    wait_n(1);
    chk("R11 resume", 6'b100000);

    summary();
  end

endmodule